// File: doc/BRIEF.md
# Video Sync and Blank Conditioner

This block takes the horizontal sync, vertical sync and blanking strobes from a display timing source and turns them into the sync outputs that drive a monitor. It also produces a flag that switches off the sync current source of the green analog channel. All three inputs are active-low. The block has two operating modes, chosen by a static mode-select pin.

In normal mode the strobes are sampled on the falling edge of the pixel clock. They then travel through a pipeline of rising-edge stages, so that they leave the block in step with the pixel data path. A last output stage applies a programmable true/complement polarity to each sync line. In pass-through mode the strobes are sampled on the rising edge of a separate alternate clock. They are forwarded untouched, because the upstream source already provides the polarities the monitor needs. The two polarity bits sit in a small control register that a write strobe loads. Bus decoding, the DACs and any external sync selection are outside this block.

The sync-current disable flag is raised whenever either delayed sync strobe is active, whatever the blanking level is.

Top module: `vsc_top`

## Requirements
- R1: While `rst` is high at rising edges of both clocks, `hsync_o`, `vsync_o` and `blank_o` read 1, `sync_off_o` reads 0, and both polarity bits read 1.
- R2: In normal mode (`mode_pass`=0), the input levels present at a falling edge of `pix_clk` reach the outputs at the DEPTH-th rising edge of `pix_clk` after that falling edge (DEPTH=3 by default). No output changes earlier.
- R3: In normal mode, `hsync_o` equals the delayed `hsync_n` when polarity bit 0 is 1, and equals its complement when that bit is 0.
- R4: In normal mode, `vsync_o` equals the delayed `vsync_n` when polarity bit 1 is 1, and equals its complement when that bit is 0.
- R5: In pass-through mode (`mode_pass`=1), the sync levels sampled at a rising edge of `alt_clk` appear on `hsync_o` and `vsync_o` at the next rising edge of `alt_clk`. They are never inverted, whatever the polarity bits hold.
- R6: `blank_o` carries the sampled `blank_n` level without inversion, with the same latency as the sync outputs of the active mode.
- R7: `sync_off_o` is 1 exactly when the delayed `hsync_n` or `vsync_n` (in true, active-low form) is 0, independent of `blank_n`, in both modes.
- R8: At a rising edge of `pix_clk` with `ctl_we`=1, the polarity bits load `ctl_wdata` (bit 0 for horizontal, bit 1 for vertical). With `ctl_we`=0 they hold, whatever `ctl_wdata` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock; normal-mode sampling on its falling edge, pipeline and control on its rising edge |
| alt_clk | input | 1 | Alternate clock used for sampling in pass-through mode |
| rst | input | 1 | Synchronous active-high reset, seen by both clock domains |
| mode_pass | input | 1 | 1 selects pass-through mode, 0 selects normal mode |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| blank_n | input | 1 | Blanking strobe, active low |
| ctl_we | input | 1 | Write strobe for the polarity bits |
| ctl_wdata | input | 2 | Polarity bits to load: bit 0 horizontal, bit 1 vertical; 1 = true, 0 = inverted |
| hsync_o | output | 1 | Conditioned horizontal sync |
| vsync_o | output | 1 | Conditioned vertical sync |
| blank_o | output | 1 | Delayed blanking strobe, active low |
| sync_off_o | output | 1 | 1 turns off the green-channel sync current source |

## Verification
The bench sweeps every combination of the three strobes under all four polarity settings. It compares each output at the exact cycle the latency predicts, so an extra or missing pipeline stage, or capture on the wrong pixel-clock edge, shows up as a one-cycle misalignment against the expected history. Cases with sync active while blank is inactive expose a disable flag that wrongly depends on blank. Pass-through runs with the polarity bits cleared catch a design that inverts in that mode. The first run keeps the reset polarity while the write data is held at zero with the strobe low, which catches a wrong reset value and a register that loads without the strobe.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  typedef struct packed {
    logic hs;
    logic vs;
    logic blk;
  } vsc_sig_t;

  localparam vsc_sig_t VSC_IDLE = '{hs: 1'b1, vs: 1'b1, blk: 1'b1};
endpackage

// File: rtl/vsc_capture.sv
module vsc_capture
  import vsc_pkg::*;
#(
  parameter bit FALLING = 1'b0
) (
  input  logic     clk,
  input  logic     rst,
  input  vsc_sig_t d,
  output vsc_sig_t q
);
  generate
    if (FALLING) begin : g_fall
      always_ff @(negedge clk) begin
        if (rst) q <= VSC_IDLE;
        else     q <= d;
      end
    end else begin : g_rise
      always_ff @(posedge clk) begin
        if (rst) q <= VSC_IDLE;
        else     q <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/vsc_pipe.sv
module vsc_pipe
  import vsc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  vsc_sig_t d,
  output vsc_sig_t q
);
  generate
    if (STAGES == 0) begin : g_wire
      assign q = d;
    end else begin : g_line
      vsc_sig_t stg [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < STAGES; s++) stg[s] <= VSC_IDLE;
        end else begin
          stg[0] <= d;
          for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
      end
      assign q = stg[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/vsc_outstage.sv
module vsc_outstage
  import vsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pol,
  input  vsc_sig_t   d,
  output logic       hs_o,
  output logic       vs_o,
  output logic       blk_o,
  output logic       soff_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_o   <= 1'b1;
      vs_o   <= 1'b1;
      blk_o  <= 1'b1;
      soff_o <= 1'b0;
    end else begin
      hs_o   <= pol[0] ? d.hs : ~d.hs;
      vs_o   <= pol[1] ? d.vs : ~d.vs;
      blk_o  <= d.blk;
      soff_o <= ~(d.hs & d.vs);
    end
  end
endmodule

// File: rtl/vsc_top.sv
module vsc_top
  import vsc_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic       pix_clk,
  input  logic       alt_clk,
  input  logic       rst,
  input  logic       mode_pass,
  input  logic       hsync_n,
  input  logic       vsync_n,
  input  logic       blank_n,
  input  logic       ctl_we,
  input  logic [1:0] ctl_wdata,
  output logic       hsync_o,
  output logic       vsync_o,
  output logic       blank_o,
  output logic       sync_off_o
);
  localparam int PIPE_N = (DEPTH > 1) ? DEPTH - 1 : 0;

  vsc_sig_t   in_sig, cap_pix, cap_alt, dly_pix;
  logic [1:0] pol_q;
  logic       n_hs, n_vs, n_blk, n_off;
  logic       p_hs, p_vs, p_blk, p_off;

  assign in_sig.hs  = hsync_n;
  assign in_sig.vs  = vsync_n;
  assign in_sig.blk = blank_n;

  // Polarity control bits, written from the pixel-clock side
  always_ff @(posedge pix_clk) begin
    if (rst)         pol_q <= 2'b11;
    else if (ctl_we) pol_q <= ctl_wdata;
  end

  // Normal path: falling-edge sample, rising-edge delay, polarity stage
  vsc_capture #(.FALLING(1'b1)) u_cap_pix (
    .clk(pix_clk), .rst(rst), .d(in_sig), .q(cap_pix)
  );

  vsc_pipe #(.STAGES(PIPE_N)) u_pipe (
    .clk(pix_clk), .rst(rst), .d(cap_pix), .q(dly_pix)
  );

  vsc_outstage u_out_norm (
    .clk(pix_clk), .rst(rst), .pol(pol_q), .d(dly_pix),
    .hs_o(n_hs), .vs_o(n_vs), .blk_o(n_blk), .soff_o(n_off)
  );

  // Pass-through path: rising-edge sample on alternate clock, no inversion
  vsc_capture #(.FALLING(1'b0)) u_cap_alt (
    .clk(alt_clk), .rst(rst), .d(in_sig), .q(cap_alt)
  );

  vsc_outstage u_out_pass (
    .clk(alt_clk), .rst(rst), .pol(2'b11), .d(cap_alt),
    .hs_o(p_hs), .vs_o(p_vs), .blk_o(p_blk), .soff_o(p_off)
  );

  always_comb begin
    if (mode_pass) begin
      hsync_o    = p_hs;
      vsync_o    = p_vs;
      blank_o    = p_blk;
      sync_off_o = p_off;
    end else begin
      hsync_o    = n_hs;
      vsync_o    = n_vs;
      blank_o    = n_blk;
      sync_off_o = n_off;
    end
  end
endmodule

// File: rtl/vsc_check.sv
module vsc_check (
  input logic       pix_clk,
  input logic       alt_clk,
  input logic       rst,
  input logic       mode_pass,
  input logic       hsync_n,
  input logic       vsync_n,
  input logic       blank_n,
  input logic       ctl_we,
  input logic [1:0] ctl_wdata,
  input logic [1:0] pol_q,
  input logic       hsync_o,
  input logic       vsync_o,
  input logic       blank_o,
  input logic       sync_off_o
);
  p_pol_load_r8: assert property (@(posedge pix_clk) disable iff (rst)
    ctl_we |=> (pol_q == $past(ctl_wdata)));

  p_pol_hold_r8: assert property (@(posedge pix_clk) disable iff (rst)
    !ctl_we |=> $stable(pol_q));

  p_pass_sync_r5: assert property (@(posedge alt_clk) disable iff (rst)
    (mode_pass && $past(mode_pass) && !$past(rst) && !$past(rst, 2))
      |-> (hsync_o == $past(hsync_n, 2) && vsync_o == $past(vsync_n, 2)));

  p_pass_blank_r6: assert property (@(posedge alt_clk) disable iff (rst)
    (mode_pass && $past(mode_pass) && !$past(rst) && !$past(rst, 2))
      |-> (blank_o == $past(blank_n, 2)));

  p_pass_kill_r7: assert property (@(posedge alt_clk) disable iff (rst)
    (mode_pass && $past(mode_pass)) |-> (sync_off_o == !(hsync_o && vsync_o)));

  p_norm_kill_r7: assert property (@(posedge pix_clk) disable iff (rst)
    (!mode_pass && !$past(mode_pass) && $stable(pol_q))
      |-> (sync_off_o == ((pol_q[0] ? !hsync_o : hsync_o) ||
                          (pol_q[1] ? !vsync_o : vsync_o))));
endmodule

bind vsc_top vsc_check u_vsc_check (
  .pix_clk(pix_clk), .alt_clk(alt_clk), .rst(rst), .mode_pass(mode_pass),
  .hsync_n(hsync_n), .vsync_n(vsync_n), .blank_n(blank_n),
  .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .pol_q(pol_q),
  .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o),
  .sync_off_o(sync_off_o)
);

// File: tb/vsc_top_test.sv
module vsc_top_test;
  localparam int DEPTH = 3;

  logic       pix_clk = 1'b0;
  logic       alt_clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_pass = 1'b0;
  logic       hsync_n = 1'b1, vsync_n = 1'b1, blank_n = 1'b1;
  logic       ctl_we = 1'b0;
  logic [1:0] ctl_wdata = 2'b00;
  logic       hsync_o, vsync_o, blank_o, sync_off_o;

  int checks = 0;
  int fails  = 0;
  logic [2:0] hist [0:63];

  always #10 pix_clk = ~pix_clk;
  always #15 alt_clk = ~alt_clk;

  vsc_top #(.DEPTH(DEPTH)) uut (
    .pix_clk(pix_clk), .alt_clk(alt_clk), .rst(rst), .mode_pass(mode_pass),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .blank_n(blank_n),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o),
    .sync_off_o(sync_off_o)
  );

  // {hsync_o, vsync_o, blank_o, sync_off_o} expected from a vector {hs, vs, blk}
  function automatic logic [3:0] expect_out(input logic [1:0] pol, input logic [2:0] v);
    logic hs, vs, b;
    hs = v[2]; vs = v[1]; b = v[0];
    return {pol[0] ? hs : ~hs, pol[1] ? vs : ~vs, b, ~(hs & vs)};
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic write_pol(input logic [1:0] p);
    @(posedge pix_clk); #2;
    ctl_we = 1'b1; ctl_wdata = p;
    @(posedge pix_clk); #2;
    ctl_we = 1'b0; ctl_wdata = ~p;
  endtask

  task automatic run_norm(input logic [1:0] pol, input int k, input int n);
    for (int i = 0; i < n; i++) begin
      logic [2:0] v;
      v = 3'((i * (2 * k + 1) + k) % 8);
      @(posedge pix_clk); #2;
      {hsync_n, vsync_n, blank_n} = v;
      hist[i] = v;
      #3;
      if (i >= DEPTH)
        chk("R2/R3/R4/R6/R7/R8 normal", {hsync_o, vsync_o, blank_o, sync_off_o},
            expect_out(pol, hist[i-DEPTH]));
    end
  endtask

  task automatic run_pass(input int k, input int n);
    for (int i = 0; i < n; i++) begin
      logic [2:0] v;
      v = 3'((i * (2 * k + 1) + k + 5) % 8);
      @(posedge alt_clk); #2;
      {hsync_n, vsync_n, blank_n} = v;
      hist[i] = v;
      #5;
      if (i >= 2)
        chk("R5/R6/R7 pass-through", {hsync_o, vsync_o, blank_o, sync_off_o},
            expect_out(2'b11, hist[i-2]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge pix_clk);
    fails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (4) @(posedge pix_clk);
    #5;
    chk("R1 reset outputs", {hsync_o, vsync_o, blank_o, sync_off_o}, 4'b1110);
    @(posedge pix_clk); #2;
    rst = 1'b0;

    // R3/R4/R8: reset polarity 11 kept while we is low and wdata is 00
    run_norm(2'b11, 0, 24);
    write_pol(2'b00);
    run_norm(2'b00, 1, 24);
    write_pol(2'b01);
    run_norm(2'b01, 2, 24);
    write_pol(2'b10);
    run_norm(2'b10, 3, 24);

    // R5: pass-through ignores polarity bits
    write_pol(2'b00);
    mode_pass = 1'b1;
    run_pass(0, 20);
    write_pol(2'b01);
    run_pass(2, 20);

    // back to normal mode with a fresh polarity
    write_pol(2'b10);
    mode_pass = 1'b0;
    run_norm(2'b10, 1, 20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule